// File: doc/BRIEF.md
# Generation-Bit Event Notification Ring

This block is a circular queue of event numbers kept in on-chip storage. A producer appends 31-bit event numbers. A consumer either takes the oldest one (pop) or looks at it without removing it (peek). The producer and consumer share no occupancy counter. Each slot carries a generation flag next to its payload. The consumer keeps a toggle that flips each time its read index wraps. A slot holds a live event exactly when its generation flag differs from that toggle.

The producer writes the inverse of its own generation bit into every slot and flips that bit on each of its wraps. Stale slots therefore read as empty on the consumer's next pass without being cleared. The producer refuses an event that would overrun unread entries and flags the refusal. This leaves one slot always unused.

A global enable marks the ring as set up. While it is low, the ring behaves as an unallocated queue: reads return zero and pushes are ignored.

Top module: `gen_event_ring`

## Requirements
- R1: An accepted push appends its 31-bit event. A pop that finds an entry returns the oldest one, with `rd_valid` high and `rd_event` holding the payload in the cycle after the request.
- R2: First-in first-out order and full payload values are kept across any number of wraps of both the write and the read positions.
- R3: A peek (with `pop_req` low) returns the oldest entry one cycle later in the same way as a pop. It does not remove the entry, so repeated peeks and a following pop all return the same event.
- R4: When `pop_req` and `peek_req` are both high, the request acts as a pop.
- R5: A pop or peek on an empty ring gives `rd_valid` low and `rd_event` zero in the next cycle. In any cycle after a cycle with no read request, `rd_valid` is low and `rd_event` is zero.
- R6: The ring holds at most DEPTH-1 events. A push made while DEPTH-1 events are held is dropped, and `overflow` is high for exactly the following cycle. Occupancy is judged before any pop made in the same cycle. A dropped push leaves the contents unchanged.
- R7: A push and a pop in the same cycle on an empty ring: the pop reports empty, and the pushed event is returned by the next read.
- R8: While `ring_live` is low, pushes are ignored without raising `overflow`, reads return `rd_valid` low and `rd_event` zero, and nothing is consumed. Contents stored before are still returned once `ring_live` is high again.
- R9: During reset and after it, the ring is empty and `rd_valid`, `rd_event` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_live | input | 1 | Ring is set up; low makes it behave as unallocated |
| push_valid | input | 1 | Producer offers an event this cycle |
| push_event | input | 31 | Event number to append |
| overflow | output | 1 | Previous cycle's push was dropped because the ring was full |
| pop_req | input | 1 | Consume the oldest event |
| peek_req | input | 1 | Read the oldest event without consuming it |
| rd_valid | output | 1 | `rd_event` holds an event read by the previous cycle's request |
| rd_event | output | 31 | Event returned by the read, zero when none |

## Verification
The hardest state to reach is a consumer that lags the producer by many slots while both positions have wrapped several times. Stale slots then carry a generation flag that is valid on one pass and stale on the next. A full ring that receives a push and a pop in the same cycle is also hard to reach. The stimulus first fills the ring to its capacity and drains it deliberately. It then runs a long stream whose push and pop rates alternate between filling and draining phases, so that the occupancy repeatedly sweeps between empty and full across many wraps. A behavioural queue model is compared with the outputs on every cycle.

// File: rtl/evring_pkg.sv
package evring_pkg;
  localparam int unsigned EV_W = 31;

  typedef struct packed {
    logic            gen;
    logic [EV_W-1:0] ev;
  } slot_t;
endpackage

// File: rtl/evring_rst_sync.sv
module evring_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/evring_slots.sv
module evring_slots
  import evring_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  slot_t            wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output slot_t            rd_word
);
  slot_t slot_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    slot_t slot_q;
    logic  hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (hit) begin
        slot_q <= wr_word;
      end
    end

    assign slot_arr[g] = slot_q;
  end

  assign rd_word = slot_arr[rd_idx];
endmodule

// File: rtl/evring_prod.sv
module evring_prod
  import evring_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             push_valid,
  input  logic [EV_W-1:0]  push_ev,
  input  logic [IDX_W-1:0] cons_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output slot_t            wr_word,
  output logic             overflow_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d, idx_inc;
  logic             gen_q, gen_d;
  logic             ovf_q, ovf_d;
  logic             full, accept;

  assign idx_inc = idx_q + 1'b1;
  assign full    = (idx_inc == cons_idx);
  assign accept  = live && push_valid && !full;

  always_comb begin
    idx_d = idx_q;
    gen_d = gen_q;
    if (accept) begin
      idx_d = idx_inc;
      if (idx_inc == '0) begin
        gen_d = ~gen_q;
      end
    end
    ovf_d = live && push_valid && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      gen_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      gen_q <= gen_d;
      ovf_q <= ovf_d;
    end
  end

  assign wr_en      = accept;
  assign wr_idx     = idx_q;
  assign wr_word    = '{gen: ~gen_q, ev: push_ev};
  assign overflow_o = ovf_q;

  assert_overflow_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> ($past(push_valid) && !$past(wr_en)));

  assert_gen_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == LAST) |=> (gen_q != $past(gen_q)));

  assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !wr_en);
endmodule

// File: rtl/evring_cons.sv
module evring_cons
  import evring_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             pop_req,
  input  logic             peek_req,
  input  slot_t            slot_word,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid_o,
  output logic [EV_W-1:0]  rd_ev_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d, idx_inc;
  logic             tog_q, tog_d;
  logic             vld_q, vld_d;
  logic [EV_W-1:0]  ev_q, ev_d;
  logic             has_entry, take, look;

  assign idx_inc   = idx_q + 1'b1;
  assign has_entry = (slot_word.gen != tog_q);
  assign take      = live && pop_req && has_entry;
  assign look      = live && (pop_req || peek_req) && has_entry;

  always_comb begin
    idx_d = idx_q;
    tog_d = tog_q;
    if (take) begin
      idx_d = idx_inc;
      if (idx_inc == '0) begin
        tog_d = ~tog_q;
      end
    end
    vld_d = look;
    ev_d  = look ? slot_word.ev : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      tog_q <= 1'b0;
      vld_q <= 1'b0;
      ev_q  <= '0;
    end else begin
      idx_q <= idx_d;
      tog_q <= tog_d;
      vld_q <= vld_d;
      ev_q  <= ev_d;
    end
  end

  assign rd_idx     = idx_q;
  assign rd_valid_o = vld_q;
  assign rd_ev_o    = ev_q;

  assert_wrap_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx_q == LAST) |=> (tog_q != $past(tog_q)));

  assert_peek_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_req && !pop_req) |=> ($stable(idx_q) && $stable(tog_q)));

  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_ev_o == '0));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (!rd_valid_o && $stable(idx_q)));
endmodule

// File: rtl/gen_event_ring.sv
module gen_event_ring
  import evring_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ring_live,
  input  logic            push_valid,
  input  logic [EV_W-1:0] push_event,
  output logic            overflow,
  input  logic            pop_req,
  input  logic            peek_req,
  output logic            rd_valid,
  output logic [EV_W-1:0] rd_event
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic             srst_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  slot_t            wr_word;
  slot_t            rd_word;

  evring_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  evring_slots #(.DEPTH(DEPTH)) u_slots (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_word (wr_word),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  evring_prod #(.DEPTH(DEPTH)) u_prod (
    .clk        (clk),
    .rst_n      (srst_n),
    .live       (ring_live),
    .push_valid (push_valid),
    .push_ev    (push_event),
    .cons_idx   (rd_idx),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_word    (wr_word),
    .overflow_o (overflow)
  );

  evring_cons #(.DEPTH(DEPTH)) u_cons (
    .clk        (clk),
    .rst_n      (srst_n),
    .live       (ring_live),
    .pop_req    (pop_req),
    .peek_req   (peek_req),
    .slot_word  (rd_word),
    .rd_idx     (rd_idx),
    .rd_valid_o (rd_valid),
    .rd_ev_o    (rd_event)
  );

  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |-> (wr_idx + 1'b1 != rd_idx));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !srst_n |-> (!rd_valid && !overflow && rd_event == '0));
endmodule

// File: tb/gen_event_ring_tb_top.sv
`timescale 1ns/100ps
module gen_event_ring_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ring_live = 1'b0;
  logic        push_valid = 1'b0;
  logic [30:0] push_event = '0;
  logic        pop_req = 1'b0;
  logic        peek_req = 1'b0;
  logic        overflow;
  logic        rd_valid;
  logic [30:0] rd_event;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [30:0] mq[$];
  int          pops_done = 0;
  logic        exp_v = 0;
  logic [30:0] exp_d = '0;
  logic        exp_o = 0;
  string       rd_tag = "R9";
  string       ov_tag = "R9";
  logic [31:0] lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  gen_event_ring #(.DEPTH(DEPTH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_live  (ring_live),
    .push_valid (push_valid),
    .push_event (push_event),
    .overflow   (overflow),
    .pop_req    (pop_req),
    .peek_req   (peek_req),
    .rd_valid   (rd_valid),
    .rd_event   (rd_event)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // One cycle: check outputs of the previous request, drive new inputs, update model.
  task automatic step(bit live, bit psh, logic [30:0] ev, bit pop, bit peek);
    int pre;
    bit acc_push, acc_pop;
    @(negedge clk);
    chk(rd_tag, "rd_valid", {31'd0, rd_valid}, {31'd0, exp_v});
    chk(rd_tag, "rd_event", {1'b0, rd_event}, {1'b0, exp_d});
    chk(ov_tag, "overflow", {31'd0, overflow}, {31'd0, exp_o});
    ring_live  = live;
    push_valid = psh;
    push_event = ev;
    pop_req    = pop;
    peek_req   = peek;
    pre = mq.size();
    exp_v = 0; exp_d = '0; exp_o = 0;
    acc_push = 0; acc_pop = 0;
    if (!live) begin
      rd_tag = "R8"; ov_tag = "R8";
    end else begin
      ov_tag = "R6";
      rd_tag = "R5";
      if ((pop || peek) && pre > 0) begin
        exp_v = 1; exp_d = mq[0];
        if (pop && peek) rd_tag = "R4";
        else if (pop) rd_tag = (pops_done >= DEPTH) ? "R2" : "R1";
        else rd_tag = "R3";
        acc_pop = pop;
      end else if (pop && psh && pre == 0) begin
        rd_tag = "R7";
      end
      if (psh) begin
        if (pre < DEPTH - 1) acc_push = 1;
        else exp_o = 1;
      end
    end
    if (acc_pop) begin
      void'(mq.pop_front());
      pops_done++;
    end
    if (acc_push) mq.push_back(ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9", "rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    chk("R9", "rd_event in reset", {1'b0, rd_event}, 32'd0);
    chk("R9", "overflow in reset", {31'd0, overflow}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    // empty reads after reset
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 1, 0);
    // fill past capacity: 7 accepted, then overflow twice
    for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 31'h100 + 31'(i), 0, 0);
    step(1, 0, 0, 0, 0);
    // overflow with a same-cycle pop: still dropped
    step(1, 1, 31'h0dead, 1, 0);
    // peeks do not consume; pop+peek acts as pop
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 1, 1);
    step(1, 0, 0, 0, 1);
    step(1, 1, 31'h7fff_ffff, 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 1, 0);
    // push and pop together on an empty ring
    step(1, 1, 31'h55aa, 1, 0);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    // disabled ring ignores everything
    step(1, 1, 31'h321, 0, 0);
    step(0, 1, 31'h999, 1, 0);
    step(0, 0, 0, 0, 1);
    step(0, 1, 31'h998, 0, 0);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    // long traffic with fill and drain phases across many wraps
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = rnd();
      bit filling = ((i / 64) % 2) == 0;
      bit psh = filling ? (r[1:0] != 2'b00) : (r[1:0] == 2'b00);
      bit pop = filling ? (r[3:2] == 2'b00) : (r[3:2] != 2'b00);
      bit pk  = r[6:4] == 3'b000;
      bit lv  = r[12:7] != 6'd0;
      step(lv, psh, rnd() & 32'h7fff_ffff, pop, pk);
    end
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule